// File: doc/BRIEF.md
# Protection Region Endpoint Matcher

This block decides how a single memory access lines up against one physical protection region. The access is given as a byte address and a byte length. The region is described by an address register that stores a byte address divided by four, a second register that belongs to the region just below it, and a 2-bit mode that says how to read them. The block works out the region's lower and upper bounds for the selected mode. It then tests two endpoints of the access: its first byte address, and the address one past its last byte.

The result is a 2-bit count of how many of those two endpoints fall inside the region. A count of two means the access lies fully inside, one means it straddles a bound, and zero means it misses. A caller that scans several regions can use the count to tell a clean hit from a partial overlap, which it must normally treat as a fault. Each access is presented for one cycle with a valid strobe. The count appears one clock later, so a new access can be accepted on every cycle.

Top module: `pmp_match`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0 and `matchCount` is 0.
- R2: `outValid` is high exactly in the cycle after a cycle with `inValid` high. Back-to-back accesses give back-to-back results, each carrying the count for its own access.
- R3: In every cycle where `outValid` is low, `matchCount` is 0.
- R4: Mode code 0 (off) gives a count of 0 whatever the registers and the access hold.
- R5: Mode code 1 (range below): an endpoint matches when `prevReg*4` is at or below it and it is strictly below `curReg*4`. If `prevReg` is at or above `curReg`, the count is 0.
- R6: Mode code 2 (four-byte word): an endpoint matches when it lies in the interval from `curReg*4` up to, but not including, `curReg*4+4`.
- R7: Mode code 3 (aligned power-of-two): with `a = curReg`, where `a+1` is formed one bit wider than the register, the lower bound is `(a & (a+1))*4` and the upper bound, which is excluded, is `(a | (a+1))*4`. A register of all ones therefore covers every address.
- R8: The two endpoints are `accAddr` and `accAddr+accLen`, formed one bit wider than the address so the sum never wraps. The count is the number of matching endpoints, from 0 to 2. A zero length never gives a count of 1.
- R9: An endpoint equal to the region's upper bound does not match. An access that ends exactly at the top of a region therefore counts 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An access is presented this cycle |
| mode | input | 2 | Region mode: 0 off, 1 range below, 2 four-byte word, 3 aligned power-of-two |
| prevReg | input | ADDR_W-2 | Address register of the region below (floor in mode 1), byte address divided by 4 |
| curReg | input | ADDR_W-2 | Address register of this region, byte address divided by 4 |
| accAddr | input | ADDR_W | Byte address of the access |
| accLen | input | LEN_W | Access length in bytes |
| outValid | output | 1 | `matchCount` holds the result of the previous cycle's access |
| matchCount | output | 2 | Number of access endpoints inside the region (0, 1 or 2) |

## Verification
A mode decoded into the wrong strobe, or a bound that is off by four bytes, shows at the ports only on accesses that sit on a region edge. The stimulus therefore places endpoints just below, on and just above every bound, and a wrong bound turns a count of 2 into 1, or 1 into 0, in the very next result cycle. If the sum is computed without the extra bit, it wraps only near the top of the address space, so one access is placed there on purpose. A stuck or misaligned valid register shows up one cycle later, when the scoreboard sees a missing or extra result.

// File: rtl/pmp_match_pkg.sv
package pmp_match_pkg;

  // Region mode codes, fixed by the 2-bit mode port encoding.
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } regionMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic selTor;
    logic selNa4;
    logic selNapot;
    logic capture;
  } matchStrobe_t;

endpackage

// File: rtl/pmp_match_ctrl.sv
module pmp_match_ctrl
  import pmp_match_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   mode,
  output matchStrobe_t strobe,
  output logic         outValid
);

  regionMode_e modeDec;

  always_comb begin
    modeDec         = regionMode_e'(mode);
    strobe          = '0;
    strobe.capture  = inValid;
    unique case (modeDec)
      MODE_TOR:   strobe.selTor   = 1'b1;
      MODE_NA4:   strobe.selNa4   = 1'b1;
      MODE_NAPOT: strobe.selNapot = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/pmp_match_dp.sv
module pmp_match_dp
  import pmp_match_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  matchStrobe_t      strobe,
  input  logic [ADDR_W-3:0] prevReg,
  input  logic [ADDR_W-3:0] curReg,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LEN_W-1:0]  accLen,
  output logic [1:0]        matchCount
);

  localparam int REG_W   = ADDR_W - 2;
  localparam int EXT_W   = ADDR_W + 1;
  localparam int NUM_END = 2;

  // Candidate bounds, all one bit wider than the byte address.
  logic [EXT_W-1:0] torLo, torHi, na4Lo, na4Hi, napotLo, napotHi;
  logic [REG_W:0]   curWide, curInc, napotBase, napotTop;

  always_comb begin
    torLo     = {1'b0, prevReg, 2'b00};
    torHi     = {1'b0, curReg, 2'b00};
    na4Lo     = {1'b0, curReg, 2'b00};
    na4Hi     = na4Lo + EXT_W'(4);
    curWide   = {1'b0, curReg};
    curInc    = curWide + {{REG_W{1'b0}}, 1'b1};
    napotBase = curWide & curInc;
    napotTop  = curWide | curInc;
    napotLo   = {napotBase, 2'b00};
    napotHi   = {napotTop, 2'b00};
  end

  // Bound select driven by the control strobes.
  logic [EXT_W-1:0] boundLo, boundHi;
  logic             inRegion;

  always_comb begin
    boundLo  = '0;
    boundHi  = '0;
    inRegion = strobe.selTor | strobe.selNa4 | strobe.selNapot;
    if (strobe.selTor) begin
      boundLo = torLo;
      boundHi = torHi;
    end else if (strobe.selNa4) begin
      boundLo = na4Lo;
      boundHi = na4Hi;
    end else if (strobe.selNapot) begin
      boundLo = napotLo;
      boundHi = napotHi;
    end
  end

  // Endpoints: first byte and one past the last byte.
  logic [EXT_W-1:0] endPt [NUM_END];
  logic [NUM_END-1:0] endHit;

  always_comb begin
    endPt[0] = {1'b0, accAddr};
    endPt[1] = {1'b0, accAddr} + EXT_W'(accLen);
  end

  for (genvar g = 0; g < NUM_END; g++) begin : gEnd
    always_comb
      endHit[g] = inRegion && (endPt[g] >= boundLo) && (endPt[g] < boundHi);
  end

  logic [1:0] countNext;
  always_comb countNext = {1'b0, endHit[0]} + {1'b0, endHit[1]};

  always_ff @(posedge clk) begin
    if (!rstN)               matchCount <= 2'd0;
    else if (strobe.capture) matchCount <= countNext;
    else                     matchCount <= 2'd0;
  end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_match_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-3:0] prevReg,
  input  logic [ADDR_W-3:0] curReg,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LEN_W-1:0]  accLen,
  output logic              outValid,
  output logic [1:0]        matchCount
);

  matchStrobe_t strobe;

  pmp_match_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pmp_match_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .prevReg    (prevReg),
    .curReg     (curReg),
    .accAddr    (accAddr),
    .accLen     (accLen),
    .matchCount (matchCount)
  );

endmodule

// File: rtl/pmp_match_chk.sv
module pmp_match_chk #(
  parameter int ADDR_W = 34,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        mode,
  input logic [ADDR_W-3:0] prevReg,
  input logic [ADDR_W-3:0] curReg,
  input logic [ADDR_W-1:0] accAddr,
  input logic [LEN_W-1:0]  accLen,
  input logic              outValid,
  input logic [1:0]        matchCount
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> matchCount == 2'd0);

  a_r4_off_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'd0) |=> matchCount == 2'd0);

  a_r5_empty_tor: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'd1 && prevReg >= curReg) |=> matchCount == 2'd0);

  a_r8_count_range: assert property (@(posedge clk) disable iff (!rstN)
    matchCount != 2'd3);

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && accLen == '0) |=> matchCount != 2'd1);

endmodule

bind pmp_match pmp_match_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .mode       (mode),
  .prevReg    (prevReg),
  .curReg     (curReg),
  .accAddr    (accAddr),
  .accLen     (accLen),
  .outValid   (outValid),
  .matchCount (matchCount)
);

// File: tb/pmp_match_test.sv
module pmp_match_test;

  localparam int ADDR_W = 34;
  localparam int LEN_W  = 4;
  localparam int REG_W  = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [1:0]        mode = '0;
  logic [REG_W-1:0]  prevReg = '0;
  logic [REG_W-1:0]  curReg = '0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [LEN_W-1:0]  accLen = '0;
  logic              outValid;
  logic [1:0]        matchCount;

  int checks = 0;
  int bad = 0;
  bit running = 1'b1;

  typedef struct {
    int         count;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  pmp_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .prevReg(prevReg), .curReg(curReg), .accAddr(accAddr), .accLen(accLen),
    .outValid(outValid), .matchCount(matchCount)
  );

  // Reference model written from the requirements.
  function automatic int refCount(int m, longint p, longint c, longint a, longint l);
    longint lo, hi, e0, e1, inc;
    int n;
    lo = 0; hi = 0;
    case (m)
      1: begin lo = p * 4; hi = c * 4; end
      2: begin lo = c * 4; hi = c * 4 + 4; end
      3: begin inc = c + 1; lo = (c & inc) * 4; hi = (c | inc) * 4; end
      default: begin lo = 0; hi = 0; end
    endcase
    e0 = a;
    e1 = a + l;
    n = 0;
    if (m != 0 && e0 >= lo && e0 < hi) n++;
    if (m != 0 && e1 >= lo && e1 < hi) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int m, input longint p, input longint c,
                       input longint a, input longint l, input string req);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    mode    = m[1:0];
    prevReg = p[REG_W-1:0];
    curReg  = c[REG_W-1:0];
    accAddr = a[ADDR_W-1:0];
    accLen  = l[LEN_W-1:0];
    it.count = refCount(m, p, c, a, l);
    it.req   = req;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: samples halfway between edges.
  always @(posedge clk) begin
    #5;
    if (rstN && running) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(matchCount == it.count[1:0], it.req, int'(matchCount), it.count);
        end
      end else begin
        check(matchCount == 2'd0, "R3 idle count", int'(matchCount), 0);
        if (expQ.size() != 0) begin
          check(1'b0, "R2 missing result", 0, 1);
          void'(expQ.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);
    check(matchCount == 2'd0, "R1 reset count", int'(matchCount), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    check(outValid == 1'b0, "R1 first cycle valid", int'(outValid), 0);

    // R4: off mode, registers that would otherwise match
    drive(0, 'h0, 'h800, 'h1000, 8, "R4 off ignores region");
    // R5: range below, floor 0x1000 top 0x2000
    drive(1, 'h400, 'h800, 'h1000, 8, "R5 tor full");
    drive(1, 'h400, 'h800, 'hFFC, 4, "R5 tor low straddle");
    drive(1, 'h400, 'h800, 'h3000, 4, "R5 tor miss");
    drive(1, 'h800, 'h400, 'h1000, 4, "R5 tor empty range");
    drive(1, 'h400, 'h400, 'h1000, 0, "R5 tor equal regs");
    // R9: end exactly at top bound
    drive(1, 'h400, 'h800, 'h1FF8, 8, "R9 tor end at top");
    idle(2);
    // R6: four-byte word at 0x1000
    drive(2, 'h0, 'h400, 'h1000, 2, "R6 na4 inside");
    drive(2, 'h0, 'h400, 'h1000, 4, "R9 na4 end at top");
    drive(2, 'h0, 'h400, 'hFFC, 4, "R6 na4 from below");
    drive(2, 'h0, 'h400, 'h1004, 4, "R6 na4 above");
    // R7: power-of-two, a=0x403 -> [0x1000, 0x101C)
    drive(3, 'h0, 'h403, 'h1000, 8, "R7 napot inside");
    drive(3, 'h0, 'h403, 'h1018, 4, "R9 napot end at top");
    drive(3, 'h0, 'h403, 'hFF8, 8, "R7 napot below");
    drive(3, 'h0, longint'(64'hFFFF_FFFF), 'h3_FFFF_FFF0, 8, "R7 napot all ones");
    idle(1);
    // R8: no wrap near the top of the address space, and zero length
    drive(1, 'h0, 'h40, 'h3_FFFF_FFFC, 8, "R8 no wrap");
    drive(2, 'h0, 'h400, 'h1000, 0, "R8 zero length");
    drive(3, 'h0, 'h403, 'h101C, 0, "R8 zero length at top");
    // R2: back-to-back with mode changes each cycle
    for (int i = 0; i < 8; i++)
      drive(i % 4, 'h100, 'h203, longint'('h400 + i * 'h204), i, "R2 back to back");
    idle(4);
    check(expQ.size() == 0, "R2 queue drained", expQ.size(), 0);
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule